// File: doc/BRIEF.md
# Split-Port Double-Rate Burst Memory

This block is the front end and storage of an eight-bank burst memory. Its read data and its write data use separate ports. A single command bus is sampled on each rising clock edge. It carries an operation code, a bank, a row and a column. Write data arrives as a pair of words per cycle: an even word and an odd word, standing in for the two clock edges. Read data leaves as a pair of words per cycle on a separate output, qualified by a valid strobe, after a fixed latency.

A mode command selects a burst length of 2, 4 or 8 words, which is 1, 2 or 4 pair-cycles. Each burst walks through consecutive column pairs, starting from the command's column rounded down to the burst length.

A refresh command names one bank. The row it refreshes comes from a counter that belongs to that bank. The block reports the refreshed row so the surrounding logic can track it. Because reads and writes never share wires, a read may start while a write burst is still running. A command that would restart a busy port is rejected and flagged instead.

Top module: `sio_burst_mem`

## Requirements
- R1: After reset the burst length is 2 words (one pair-cycle), every bank's refresh counter is 0, and rd_valid_o, cmd_err_o and ref_stb_o are low.
- R2: cmd_i is sampled on rising edges with the codes 0 = idle, 1 = read, 2 = write, 3 = bank refresh, 4 = mode set; codes 5 to 7 act as idle and produce no output activity.
- R3: A mode set with col_i = 1, 2 or 3 selects a burst of 2, 4 or 8 words; any other col_i value is rejected and the previous burst length is kept.
- R4: A write takes the pair (wd_even_i, wd_odd_i) in its command cycle and in each of the following BL/2-1 cycles, storing them at consecutive column pairs starting from col_i rounded down to a multiple of BL.
- R5: A read drives rd_valid_o high for exactly BL/2 cycles. The first pair appears RD_LAT cycles after the command cycle, and the pairs come from consecutive column pairs starting at the aligned column.
- R6: A read issued in the cycle after a write to the same burst returns the complete new burst, including pairs still being written. A read issued one cycle before a write to the same burst returns the old contents.
- R7: A read may be issued while a write burst is in progress, and a write may be issued while a read burst is in progress, with no idle cycles and no error.
- R8: A write during a pending write burst, a read during a pending read burst, or a mode set while either burst is pending raises cmd_err_o for one cycle (the cycle after the command). The command is otherwise ignored.
- R9: A refresh to bank b raises ref_stb_o for one cycle after the command, with ref_row_o set to bank b's counter value. That counter then increments and wraps at 2^ROW_W; the other banks' counters are unaffected.
- R10: The same row and column in different banks are separate storage locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Operation code |
| bank_i | input | 3 | Bank select |
| row_i | input | ROW_W | Row address |
| col_i | input | COL_W | Column address; burst-length code for a mode set |
| wd_even_i | input | WORD_W | Write word for the first half of the cycle |
| wd_odd_i | input | WORD_W | Write word for the second half of the cycle |
| rd_even_o | output | WORD_W | Read word for the first half of the cycle |
| rd_odd_o | output | WORD_W | Read word for the second half of the cycle |
| rd_valid_o | output | 1 | Read pair on the output is valid |
| cmd_err_o | output | 1 | Previous command was rejected because a port was busy |
| ref_stb_o | output | 1 | A bank refresh was performed |
| ref_row_o | output | ROW_W | Row refreshed by the last refresh |

## Verification
The hardest case to reach is a read whose burst overlaps a write burst to the same row, with one cycle between the two commands. In that case the memory array is written and read in the same cycles at neighbouring column pairs. The stimulus selects an eight-word burst and issues a write followed immediately by a read of the same row. It also issues the reverse order. A behavioural model predicts new or old data pair by pair. Busy-port rejections are reached the same way, by issuing a second command of the same kind, or a mode set, one cycle into a running burst.

// File: rtl/sio_burst_mem.sv
module sio_burst_mem #(
  parameter int WORD_W = 18,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [2:0]        bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [WORD_W-1:0] wd_even_i,
  input  logic [WORD_W-1:0] wd_odd_i,
  output logic [WORD_W-1:0] rd_even_o,
  output logic [WORD_W-1:0] rd_odd_o,
  output logic              rd_valid_o,
  output logic              cmd_err_o,
  output logic              ref_stb_o,
  output logic [ROW_W-1:0]  ref_row_o
);
  localparam int PC_W  = COL_W - 1;
  localparam int PA_W  = 3 + ROW_W + PC_W;
  localparam int DEPTH = 1 << PA_W;
  localparam int BANKS = 8;

  logic [COL_W-1:0]  bl_pairs;
  logic [COL_W-1:0]  wr_left, rd_left;
  logic [PA_W-1:0]   wr_ptr, rd_ptr;
  logic [WORD_W-1:0] mem_e [DEPTH];
  logic [WORD_W-1:0] mem_o [DEPTH];
  logic [ROW_W-1:0]  rcnt [BANKS];
  logic [RD_LAT-1:0] pv;
  logic [WORD_W-1:0] pe [RD_LAT];
  logic [WORD_W-1:0] po [RD_LAT];

  wire cmd_rd  = cmd_i == 3'd1;
  wire cmd_wr  = cmd_i == 3'd2;
  wire cmd_ref = cmd_i == 3'd3;
  wire cmd_mrs = cmd_i == 3'd4;
  wire wr_busy = wr_left != '0;
  wire rd_busy = rd_left != '0;
  wire wr_go   = cmd_wr & ~wr_busy;
  wire rd_go   = cmd_rd & ~rd_busy;
  wire mrs_go  = cmd_mrs & ~wr_busy & ~rd_busy;
  wire err     = (cmd_wr & wr_busy) | (cmd_rd & rd_busy) | (cmd_mrs & (wr_busy | rd_busy));

  logic [PC_W-1:0] amask;
  assign amask = ~PC_W'(bl_pairs - 1'b1);
  wire [PA_W-1:0] cmd_pa = {bank_i, row_i, col_i[COL_W-1:1] & amask};
  wire            wr_en  = wr_go | wr_busy;
  wire            rd_en  = rd_go | rd_busy;
  wire [PA_W-1:0] wr_pa  = wr_go ? cmd_pa : wr_ptr;
  wire [PA_W-1:0] rd_pa  = rd_go ? cmd_pa : rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_e[wr_pa] <= wd_even_i;
      mem_o[wr_pa] <= wd_odd_i;
    end
    pe[0] <= mem_e[rd_pa];
    po[0] <= mem_o[rd_pa];
    for (int i = 1; i < RD_LAT; i++) begin
      pe[i] <= pe[i-1];
      po[i] <= po[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_pairs  <= COL_W'(1);
      wr_left   <= '0;
      rd_left   <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      pv        <= '0;
      cmd_err_o <= 1'b0;
      ref_stb_o <= 1'b0;
      ref_row_o <= '0;
      for (int b = 0; b < BANKS; b++) rcnt[b] <= '0;
    end else begin
      pv        <= (pv << 1) | RD_LAT'(rd_en);
      cmd_err_o <= err;
      ref_stb_o <= cmd_ref;
      if (wr_go) begin
        wr_left <= bl_pairs - 1'b1;
        wr_ptr  <= cmd_pa + 1'b1;
      end else if (wr_busy) begin
        wr_left <= wr_left - 1'b1;
        wr_ptr  <= wr_ptr + 1'b1;
      end
      if (rd_go) begin
        rd_left <= bl_pairs - 1'b1;
        rd_ptr  <= cmd_pa + 1'b1;
      end else if (rd_busy) begin
        rd_left <= rd_left - 1'b1;
        rd_ptr  <= rd_ptr + 1'b1;
      end
      if (mrs_go) begin
        if (col_i == COL_W'(1)) bl_pairs <= COL_W'(1);
        else if (col_i == COL_W'(2)) bl_pairs <= COL_W'(2);
        else if (col_i == COL_W'(3)) bl_pairs <= COL_W'(4);
      end
      if (cmd_ref) begin
        ref_row_o    <= rcnt[bank_i];
        rcnt[bank_i] <= rcnt[bank_i] + 1'b1;
      end
    end
  end

  assign rd_valid_o = pv[RD_LAT-1];
  assign rd_even_o  = pe[RD_LAT-1];
  assign rd_odd_o   = po[RD_LAT-1];
endmodule

module sio_burst_mem_chk #(
  parameter int COL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] bl_pairs,
  input logic             cmd_err_o,
  input logic             ref_stb_o
);
  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_o |-> ($past(cmd_i) == 3'd1 || $past(cmd_i) == 3'd2 || $past(cmd_i) == 3'd4));
  // R9
  ref_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb_o |-> $past(cmd_i) == 3'd3);
  // R3
  bad_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4 && col_i != COL_W'(1) && col_i != COL_W'(2) && col_i != COL_W'(3))
      |=> $stable(bl_pairs));
  // R3
  mode_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bl_pairs) |-> $past(cmd_i) == 3'd4);
  // R2
  idle_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) >= 3'd5) |-> (!ref_stb_o && !cmd_err_o));
endmodule

bind sio_burst_mem sio_burst_mem_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
  .bl_pairs(bl_pairs), .cmd_err_o(cmd_err_o), .ref_stb_o(ref_stb_o)
);

// File: tb/sio_burst_mem_tb.sv
module sio_burst_mem_tb_top;
  localparam int WORD_W = 18;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 3;
  localparam int RD_LAT = 3;
  localparam int NEXP   = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = '0, bank = '0;
  logic [ROW_W-1:0] row = '0;
  logic [COL_W-1:0] col = '0;
  logic [WORD_W-1:0] wde = '0, wdo = '0;
  logic [WORD_W-1:0] rde, rdo;
  logic rdv, cerr, rstb;
  logic [ROW_W-1:0] rrow;

  always #2 clk = ~clk;

  sio_burst_mem #(.WORD_W(WORD_W), .ROW_W(ROW_W), .COL_W(COL_W), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .row_i(row), .col_i(col),
    .wd_even_i(wde), .wd_odd_i(wdo), .rd_even_o(rde), .rd_odd_o(rdo),
    .rd_valid_o(rdv), .cmd_err_o(cerr), .ref_stb_o(rstb), .ref_row_o(rrow));

  int errors = 0, checks = 0, ne = 0;
  bit done = 0;
  string cur_req = "R2";

  logic [WORD_W-1:0] me [128];
  logic [WORD_W-1:0] mo [128];
  bit ev [NEXP], eerr [NEXP], estb [NEXP];
  logic [WORD_W-1:0] ee [NEXP], eo [NEXP];
  int erow [NEXP];
  int m_bl = 1, wl = 0, rl = 0, wp = 0, rp = 0;
  int rc [8];

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", cur_req, what, act, exp, ne);
    end
  endtask

  task automatic compare();
    chk("rd_valid", int'(rdv), int'(ev[ne]));
    if (ev[ne]) begin
      chk("rd_even", int'(rde), int'(ee[ne]));
      chk("rd_odd", int'(rdo), int'(eo[ne]));
    end
    chk("cmd_err", int'(cerr), int'(eerr[ne]));
    chk("ref_stb", int'(rstb), int'(estb[ne]));
    if (estb[ne]) chk("ref_row", int'(rrow), erow[ne]);
  endtask

  function automatic int pair_addr(int b, int r, int c);
    return (b << 4) | (r << 2) | ((c >> 1) & ~(m_bl - 1) & 3);
  endfunction

  task automatic step(input int c, input int b, input int r, input int co);
    int n, pa;
    bit wb, rb, err;
    @(negedge clk);
    compare();
    cmd = 3'(c); bank = 3'(b); row = ROW_W'(r); col = COL_W'(co);
    wde = WORD_W'(ne * 1237 + 11);
    wdo = WORD_W'(ne * 4021 + 7);
    n = ne + 1;
    wb = wl > 0; rb = rl > 0;
    err = (c == 2 && wb) || (c == 1 && rb) || (c == 4 && (wb || rb));
    if (c == 2 && !wb) begin
      pa = pair_addr(b, r, co);
      me[pa] = wde; mo[pa] = wdo;
      wl = m_bl - 1; wp = pa + 1;
    end else if (wb) begin
      me[wp] = wde; mo[wp] = wdo;
      wl--; wp++;
    end
    if (c == 1 && !rb) begin
      pa = pair_addr(b, r, co);
      rl = m_bl - 1; rp = pa + 1;
      ev[n+RD_LAT-1] = 1; ee[n+RD_LAT-1] = me[pa]; eo[n+RD_LAT-1] = mo[pa];
    end else if (rb) begin
      ev[n+RD_LAT-1] = 1; ee[n+RD_LAT-1] = me[rp]; eo[n+RD_LAT-1] = mo[rp];
      rl--; rp++;
    end
    if (c == 4 && !wb && !rb) begin
      if (co == 1) m_bl = 1;
      else if (co == 2) m_bl = 2;
      else if (co == 3) m_bl = 4;
    end
    if (c == 3) begin
      estb[n] = 1; erow[n] = rc[b];
      rc[b] = (rc[b] + 1) % (1 << ROW_W);
    end
    eerr[n] = err;
    ne = n;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) rc[b] = 0;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    chk("reset rd_valid", int'(rdv), 0);
    chk("reset cmd_err", int'(cerr), 0);
    chk("reset ref_stb", int'(rstb), 0);
    chk("reset ref_row", int'(rrow), 0);
    rst_n = 1'b1;
    // R1: default burst of one pair
    step(2, 0, 0, 0); idle(1); step(1, 0, 0, 0); idle(6);
    // R9: refresh counters per bank, wrap
    cur_req = "R9";
    for (int i = 0; i < 5; i++) step(3, 2, 0, 0);
    step(3, 5, 0, 0); step(3, 2, 0, 0); idle(2);
    // R2: unused codes behave as idle
    cur_req = "R2";
    step(5, 1, 1, 1); step(6, 2, 0, 0); step(7, 3, 1, 2); idle(4);
    // R3: mode set, illegal code kept
    cur_req = "R3";
    step(4, 0, 0, 2); step(4, 0, 0, 5); step(4, 0, 0, 0);
    // R4: four-word write with misaligned column
    cur_req = "R4";
    step(2, 1, 1, 2); idle(1);
    // R5: read back, two valid cycles
    cur_req = "R5";
    step(1, 1, 1, 3); idle(6);
    // R10: eight-word bursts, same row/col in two banks
    cur_req = "R10";
    step(4, 0, 0, 3);
    step(2, 3, 2, 0); idle(3); step(2, 4, 2, 0); idle(3);
    step(1, 3, 2, 0); idle(3); step(1, 4, 2, 5); idle(8);
    // R8: busy rejections
    cur_req = "R8";
    step(2, 0, 3, 0); step(2, 1, 3, 0); step(4, 0, 0, 1); idle(2);
    step(1, 0, 3, 0); step(1, 1, 3, 0); step(4, 0, 0, 2); idle(8);
    // R7: read during write and write during read
    cur_req = "R7";
    step(2, 7, 1, 0); step(1, 0, 3, 0); idle(2);
    step(1, 7, 1, 0); step(2, 6, 0, 0); idle(8);
    // R6: read right after write, and read right before write, same row
    cur_req = "R6";
    step(2, 5, 3, 0); step(1, 5, 3, 0); idle(4);
    step(1, 5, 3, 0); step(2, 5, 3, 0); idle(4);
    step(1, 5, 3, 0); idle(8);
    // R3: back to two-word bursts
    cur_req = "R3";
    step(4, 0, 0, 1); step(1, 5, 3, 4); idle(6);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule